// File: doc/BRIEF.md
# Interrupt and Exception Entry Sequencer

This block sits next to a small 32-bit processor core and makes the take-or-skip decision at every instruction boundary. The core raises a one-cycle boundary strobe and presents its current PC, the PC of the following instruction, its status word and its vector base. The same cycle carries any peripheral interrupt request with its level and event code, a debug-port interrupt command, a synchronous exception request and a return-from-handler strobe. On the next clock edge the sequencer presents a new PC and status word for the core to load. It also records the saved context and event codes, and it pulses a one-cycle load indication.

A block bit in the status word inhibits interrupts and exceptions. A low-power indication still lets interrupts through while the block bit is set. If an exception other than a breakpoint arrives while blocked, the block performs a soft reset to a fixed address. During that soft reset it leaves the saved registers alone and drives a reset code on the two status pins for a fixed number of cycles.

No data is streamed through the block. Every pin is a plain level or strobe with no back-pressure, and the core only needs to hold the boundary inputs valid during the strobe cycle.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, load_o is 0, kind_o is 0, stat_o is 2'b00, and pc_o, sr_o, saved and code outputs are all zero.
- R2: When bnd is 0, no request causes a load, and every output holds its value.
- R3: A peripheral request is taken when the mask field (status bits 7:4) is below per_lvl and the block bit (status bit 28) is 0. On entry saved_pc_o=seq_pc, saved_sr_o=cur_sr, irq_code_o=irq_code2_o=per_code, sr_o=cur_sr with bits 28, 29 and 30 set, and pc_o=vec_base+0x600.
- R4: A debug interrupt is taken when the mask field is below 15 and the block bit is 0. It enters as in R3 with both interrupt codes set to 0x5E0, and it ranks above a peripheral request.
- R5: While the block bit is 1 interrupts are held off. A request still pending is taken at the first boundary where cur_sr has the block bit clear.
- R6: With lowpwr=1, interrupts are accepted even when the block bit is 1.
- R7: An exception with the block bit clear gives saved_pc_o=cur_pc, saved_sr_o=cur_sr, exc_evt_o=exc_code, pc_o=vec_base+0x100 and sr_o=cur_sr with bits 28 to 30 set. It ranks above return and interrupts.
- R8: With the block bit set, a breakpoint exception (exc_brk=1) is ignored, and interrupt evaluation proceeds as if no exception had been raised.
- R9: With the block bit set, any other exception sets pc_o=0xA0000000 and sr_o=cur_sr with bits 28 to 30 set and mask 15. Saved registers and code registers do not change.
- R10: After a soft reset, stat_o reads 2'b11 for exactly 4 cycles and then returns to 2'b00. A normal entry leaves it at 2'b00.
- R11: ret_stb loads pc_o=saved_pc_o and sr_o=saved_sr_o. It ranks below exceptions and above interrupts.
- R12: load_o pulses for exactly one cycle after an acted-on boundary. kind_o encodes 1 exception, 2 soft reset, 3 return, 4 debug, 5 peripheral and 0 none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bnd | input | 1 | Instruction boundary strobe |
| cur_pc | input | 32 | PC of the boundary instruction |
| seq_pc | input | 32 | PC of the following instruction |
| cur_sr | input | 32 | Current status word |
| vec_base | input | 32 | Vector base address |
| per_req | input | 1 | Peripheral interrupt request |
| per_lvl | input | 4 | Peripheral request level |
| per_code | input | 12 | Peripheral event code |
| dbg_req | input | 1 | Debug-port interrupt command |
| exc_req | input | 1 | Synchronous exception request |
| exc_brk | input | 1 | Exception is a breakpoint trap |
| exc_code | input | 12 | Exception event code |
| lowpwr | input | 1 | Sleep or standby active |
| ret_stb | input | 1 | Return-from-handler strobe |
| load_o | output | 1 | New PC/status valid, one cycle |
| kind_o | output | 3 | Kind of event taken |
| pc_o | output | 32 | Next PC |
| sr_o | output | 32 | Next status word |
| saved_pc_o | output | 32 | Saved PC |
| saved_sr_o | output | 32 | Saved status |
| irq_code_o | output | 12 | Interrupt event code |
| irq_code2_o | output | 12 | Interrupt event code copy |
| exc_evt_o | output | 12 | Exception event code |
| stat_o | output | 2 | Status pins, 2'b11 during soft reset |

## Verification
The hardest situation to reach is a non-breakpoint exception arriving while the block bit is set. It matters most when interrupts and a return are pending at the same boundary, because the soft reset must leave the saved context exactly as the previous entry left it. The stimulus first performs a normal entry to load known saved values. It then applies a blocked exception and checks that the saved and code registers are unchanged, and it follows the status pins cycle by cycle until they return to the run code. A blocked breakpoint combined with low power is driven as well, to show that the ignored trap does not hide the interrupt.

// File: rtl/exs_pkg.sv
package exs_pkg;
  typedef enum logic [2:0] {
    TK_NONE = 3'd0,
    TK_EXC  = 3'd1,
    TK_SRST = 3'd2,
    TK_RET  = 3'd3,
    TK_DBG  = 3'd4,
    TK_PER  = 3'd5
  } take_e;

  localparam int SR_MLO  = 4;
  localparam int MASK_W  = 4;
  localparam int SR_BLK  = 28;
  localparam int SR_BANK = 29;
  localparam int SR_PRIV = 30;
endpackage

// File: rtl/exs_arb.sv
module exs_arb
  import exs_pkg::*;
(
  input  logic              bnd,
  input  logic [MASK_W-1:0] mask,
  input  logic              blk,
  input  logic              lowpwr,
  input  logic              per_req,
  input  logic [MASK_W-1:0] per_lvl,
  input  logic              dbg_req,
  input  logic              exc_req,
  input  logic              exc_brk,
  input  logic              ret_stb,
  output take_e             take
);
  localparam logic [MASK_W-1:0] MASK_TOP = '1;

  logic irq_ok;
  assign irq_ok = !blk || lowpwr;

  always_comb begin
    take = TK_NONE;
    if (bnd) begin
      if (exc_req && !blk)
        take = TK_EXC;
      else if (exc_req && blk && !exc_brk)
        take = TK_SRST;
      else if (ret_stb)
        take = TK_RET;
      else if (dbg_req && (mask != MASK_TOP) && irq_ok)
        take = TK_DBG;
      else if (per_req && (mask < per_lvl) && irq_ok)
        take = TK_PER;
    end
  end
endmodule

// File: rtl/exs_hold.sv
module exs_hold #(
  parameter int HOLD = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic [1:0] stat
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LOADV = CW'(HOLD);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (start)
      cnt <= LOADV;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign stat = (cnt != '0) ? 2'b11 : 2'b00;
endmodule

// File: rtl/exs_ctx.sv
module exs_ctx
  import exs_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          CODE_W    = 12,
  parameter logic [XLEN-1:0]   IRQ_OFF   = 'h600,
  parameter logic [XLEN-1:0]   EXC_OFF   = 'h100,
  parameter logic [XLEN-1:0]   SRST_ADDR = 'hA000_0000,
  parameter logic [CODE_W-1:0] DBG_CODE  = 'h5E0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  take_e             take,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   seq_pc,
  input  logic [XLEN-1:0]   cur_sr,
  input  logic [XLEN-1:0]   vec_base,
  input  logic [CODE_W-1:0] per_code,
  input  logic [CODE_W-1:0] exc_code,
  output logic              load_o,
  output logic [2:0]        kind_o,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   sr_o,
  output logic [XLEN-1:0]   saved_pc_o,
  output logic [XLEN-1:0]   saved_sr_o,
  output logic [CODE_W-1:0] irq_code_o,
  output logic [CODE_W-1:0] irq_code2_o,
  output logic [CODE_W-1:0] exc_evt_o
);
  logic [XLEN-1:0] entry_sr;
  logic [XLEN-1:0] srst_sr;

  always_comb begin
    entry_sr = cur_sr;
    entry_sr[SR_BLK]  = 1'b1;
    entry_sr[SR_BANK] = 1'b1;
    entry_sr[SR_PRIV] = 1'b1;
    srst_sr = entry_sr;
    srst_sr[SR_MLO +: MASK_W] = '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_o      <= 1'b0;
      kind_o      <= 3'd0;
      pc_o        <= '0;
      sr_o        <= '0;
      saved_pc_o  <= '0;
      saved_sr_o  <= '0;
      irq_code_o  <= '0;
      irq_code2_o <= '0;
      exc_evt_o   <= '0;
    end else begin
      load_o <= (take != TK_NONE);
      kind_o <= take;
      unique case (take)
        TK_EXC: begin
          saved_pc_o <= cur_pc;
          saved_sr_o <= cur_sr;
          exc_evt_o  <= exc_code;
          pc_o       <= vec_base + EXC_OFF;
          sr_o       <= entry_sr;
        end
        TK_SRST: begin
          pc_o <= SRST_ADDR;
          sr_o <= srst_sr;
        end
        TK_RET: begin
          pc_o <= saved_pc_o;
          sr_o <= saved_sr_o;
        end
        TK_DBG, TK_PER: begin
          saved_pc_o  <= seq_pc;
          saved_sr_o  <= cur_sr;
          irq_code_o  <= (take == TK_DBG) ? DBG_CODE : per_code;
          irq_code2_o <= (take == TK_DBG) ? DBG_CODE : per_code;
          pc_o        <= vec_base + IRQ_OFF;
          sr_o        <= entry_sr;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exs_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 12,
  parameter int HOLD   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bnd,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   seq_pc,
  input  logic [XLEN-1:0]   cur_sr,
  input  logic [XLEN-1:0]   vec_base,
  input  logic              per_req,
  input  logic [3:0]        per_lvl,
  input  logic [CODE_W-1:0] per_code,
  input  logic              dbg_req,
  input  logic              exc_req,
  input  logic              exc_brk,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              lowpwr,
  input  logic              ret_stb,
  output logic              load_o,
  output logic [2:0]        kind_o,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   sr_o,
  output logic [XLEN-1:0]   saved_pc_o,
  output logic [XLEN-1:0]   saved_sr_o,
  output logic [CODE_W-1:0] irq_code_o,
  output logic [CODE_W-1:0] irq_code2_o,
  output logic [CODE_W-1:0] exc_evt_o,
  output logic [1:0]        stat_o
);
  take_e take;

  exs_arb u_arb (
    .bnd     (bnd),
    .mask    (cur_sr[SR_MLO +: MASK_W]),
    .blk     (cur_sr[SR_BLK]),
    .lowpwr  (lowpwr),
    .per_req (per_req),
    .per_lvl (per_lvl),
    .dbg_req (dbg_req),
    .exc_req (exc_req),
    .exc_brk (exc_brk),
    .ret_stb (ret_stb),
    .take    (take)
  );

  exs_ctx #(.XLEN(XLEN), .CODE_W(CODE_W)) u_ctx (
    .clk         (clk),
    .rst_n       (rst_n),
    .take        (take),
    .cur_pc      (cur_pc),
    .seq_pc      (seq_pc),
    .cur_sr      (cur_sr),
    .vec_base    (vec_base),
    .per_code    (per_code),
    .exc_code    (exc_code),
    .load_o      (load_o),
    .kind_o      (kind_o),
    .pc_o        (pc_o),
    .sr_o        (sr_o),
    .saved_pc_o  (saved_pc_o),
    .saved_sr_o  (saved_sr_o),
    .irq_code_o  (irq_code_o),
    .irq_code2_o (irq_code2_o),
    .exc_evt_o   (exc_evt_o)
  );

  exs_hold #(.HOLD(HOLD)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .start (take == TK_SRST),
    .stat  (stat_o)
  );
endmodule

// File: rtl/exs_chk.sv
module exs_chk #(
  parameter int XLEN   = 32,
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bnd,
  input logic [XLEN-1:0]   cur_sr,
  input logic              load_o,
  input logic [2:0]        kind_o,
  input logic [XLEN-1:0]   pc_o,
  input logic [XLEN-1:0]   sr_o,
  input logic [XLEN-1:0]   saved_pc_o,
  input logic [XLEN-1:0]   saved_sr_o,
  input logic [CODE_W-1:0] irq_code_o,
  input logic [CODE_W-1:0] irq_code2_o,
  input logic [1:0]        stat_o
);
  // R2
  load_needs_bnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |-> $past(bnd));

  // R12
  load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !load_o || $past(bnd, 1));

  // R9
  srst_keeps_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_o && kind_o == 3'd2) |-> ($stable(saved_pc_o) && $stable(saved_sr_o)
      && pc_o == 32'hA000_0000));

  // R10
  srst_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_o && kind_o == 3'd2) |-> stat_o == 2'b11);

  // R3
  irq_sets_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_o && (kind_o == 3'd4 || kind_o == 3'd5)) |->
      (sr_o[30:28] == 3'b111 && irq_code_o == irq_code2_o));

  // R11
  ret_restores_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_o && kind_o == 3'd3) |-> (pc_o == saved_pc_o && sr_o == saved_sr_o));

  // R5
  blocked_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_o && (kind_o == 3'd4 || kind_o == 3'd5)) |->
      (!$past(cur_sr[28]) || sr_o[28]));
endmodule

bind exc_entry_seq exs_chk #(.XLEN(XLEN), .CODE_W(CODE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bnd         (bnd),
  .cur_sr      (cur_sr),
  .load_o      (load_o),
  .kind_o      (kind_o),
  .pc_o        (pc_o),
  .sr_o        (sr_o),
  .saved_pc_o  (saved_pc_o),
  .saved_sr_o  (saved_sr_o),
  .irq_code_o  (irq_code_o),
  .irq_code2_o (irq_code2_o),
  .stat_o      (stat_o)
);

// File: tb/sim_exc_entry_seq.sv
module sim_exc_entry_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bnd = 1'b0;
  logic [31:0] cur_pc = '0, seq_pc = '0, cur_sr = '0, vec_base = 32'h8000_0000;
  logic        per_req = 1'b0;
  logic [3:0]  per_lvl = '0;
  logic [11:0] per_code = '0;
  logic        dbg_req = 1'b0, exc_req = 1'b0, exc_brk = 1'b0;
  logic [11:0] exc_code = 12'h1E0;
  logic        lowpwr = 1'b0, ret_stb = 1'b0;
  logic        load_o;
  logic [2:0]  kind_o;
  logic [31:0] pc_o, sr_o, saved_pc_o, saved_sr_o;
  logic [11:0] irq_code_o, irq_code2_o, exc_evt_o;
  logic [1:0]  stat_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [31:0] m_pc = '0, m_sr = '0, m_spc = '0, m_ssr = '0;
  logic [11:0] m_ic = '0, m_ec = '0;

  always #5 clk = ~clk;

  exc_entry_seq u0 (.*);

  // mask, blk, lp, preq, lvl, dbg, exc, brk, ret, expected kind
  localparam int NV = 16;
  localparam logic [17:0] VEC [NV] = '{
    {4'd0,  1'b0,1'b0,1'b1,4'd5,1'b0,1'b0,1'b0,1'b0,3'd5}, // R3
    {4'd5,  1'b0,1'b0,1'b1,4'd5,1'b0,1'b0,1'b0,1'b0,3'd0}, // R3 mask == level
    {4'd4,  1'b0,1'b0,1'b1,4'd5,1'b0,1'b0,1'b0,1'b0,3'd5}, // R3
    {4'd0,  1'b1,1'b0,1'b1,4'd9,1'b0,1'b0,1'b0,1'b0,3'd0}, // R5
    {4'd0,  1'b1,1'b1,1'b1,4'd9,1'b0,1'b0,1'b0,1'b0,3'd5}, // R6
    {4'd14, 1'b0,1'b0,1'b0,4'd0,1'b1,1'b0,1'b0,1'b0,3'd4}, // R4
    {4'd15, 1'b0,1'b0,1'b0,4'd0,1'b1,1'b0,1'b0,1'b0,3'd0}, // R4
    {4'd3,  1'b0,1'b0,1'b1,4'd9,1'b1,1'b0,1'b0,1'b0,3'd4}, // R4 over peripheral
    {4'd3,  1'b1,1'b0,1'b1,4'd9,1'b1,1'b0,1'b0,1'b0,3'd0}, // R5
    {4'd0,  1'b0,1'b0,1'b1,4'd9,1'b1,1'b1,1'b0,1'b0,3'd1}, // R7
    {4'd0,  1'b1,1'b0,1'b1,4'd9,1'b0,1'b1,1'b1,1'b0,3'd0}, // R8
    {4'd0,  1'b1,1'b1,1'b1,4'd9,1'b0,1'b1,1'b1,1'b0,3'd5}, // R8 with R6
    {4'd0,  1'b1,1'b0,1'b0,4'd0,1'b0,1'b1,1'b0,1'b0,3'd2}, // R9
    {4'd0,  1'b0,1'b0,1'b1,4'd9,1'b0,1'b0,1'b0,1'b1,3'd3}, // R11 over irq
    {4'd2,  1'b0,1'b0,1'b1,4'd9,1'b1,1'b1,1'b0,1'b1,3'd1}, // R7 over return
    {4'd0,  1'b0,1'b0,1'b0,4'd0,1'b0,1'b0,1'b0,1'b1,3'd3}  // R11
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] k);
    case (k)
      3'd1: return "R7";
      3'd2: return "R9";
      3'd3: return "R11";
      3'd4: return "R4";
      3'd5: return "R3";
      default: return "R5";
    endcase
  endfunction

  task automatic check_all(input string tag, input logic [2:0] k);
    chk({tag, "/R12 load"}, {31'd0, load_o}, {31'd0, k != 3'd0});
    chk({tag, "/R12 kind"}, {29'd0, kind_o}, {29'd0, k});
    chk({tag, " pc"}, pc_o, m_pc);
    chk({tag, " sr"}, sr_o, m_sr);
    chk({tag, " saved pc"}, saved_pc_o, m_spc);
    chk({tag, " saved sr"}, saved_sr_o, m_ssr);
    chk({tag, " irq code"}, {20'd0, irq_code_o}, {20'd0, m_ic});
    chk({tag, " irq code2"}, {20'd0, irq_code2_o}, {20'd0, m_ic});
    chk({tag, " exc code"}, {20'd0, exc_evt_o}, {20'd0, m_ec});
  endtask

  // Apply one boundary, update the model from the expected kind, then check.
  task automatic apply(input logic [17:0] v, input int i);
    logic [2:0] k;
    logic [31:0] ent;
    k = v[2:0];
    @(negedge clk);
    cur_pc   = 32'h0000_1000 + 32'(i) * 16;
    seq_pc   = cur_pc + 2;
    cur_sr   = 32'h0000_0300 | 32'(i & 15);
    cur_sr[7:4] = v[17:14];
    cur_sr[28]  = v[13];
    lowpwr   = v[12];
    per_req  = v[11];
    per_lvl  = v[10:7];
    per_code = 12'h400 + 12'(i) * 12'h20;
    dbg_req  = v[6];
    exc_req  = v[5];
    exc_brk  = v[4];
    ret_stb  = v[3];
    exc_code = 12'h1E0 + 12'(i);
    bnd = 1'b1;
    ent = cur_sr | 32'h7000_0000;
    case (k)
      3'd1: begin m_spc = cur_pc; m_ssr = cur_sr; m_ec = exc_code;
                  m_pc = vec_base + 32'h100; m_sr = ent; end
      3'd2: begin m_pc = 32'hA000_0000; m_sr = ent | 32'h0000_00F0; end
      3'd3: begin m_pc = m_spc; m_sr = m_ssr; end
      3'd4: begin m_spc = seq_pc; m_ssr = cur_sr; m_ic = 12'h5E0;
                  m_pc = vec_base + 32'h600; m_sr = ent; end
      3'd5: begin m_spc = seq_pc; m_ssr = cur_sr; m_ic = per_code;
                  m_pc = vec_base + 32'h600; m_sr = ent; end
      default: ;
    endcase
    @(negedge clk);
    bnd = 1'b0; per_req = 1'b0; dbg_req = 1'b0; exc_req = 1'b0;
    exc_brk = 1'b0; ret_stb = 1'b0; lowpwr = 1'b0;
    check_all(tag_of(k), k);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check_all("R1", 3'd0);
    chk("R1 stat", {30'd0, stat_o}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) apply(VEC[i], i);

    // R12 load is a single-cycle pulse
    @(negedge clk);
    chk("R12 pulse", {31'd0, load_o}, 32'd0);

    // R2 requests without a boundary do nothing
    @(negedge clk);
    per_req = 1'b1; per_lvl = 4'd15; dbg_req = 1'b1; exc_req = 1'b1;
    cur_sr = 32'h0; ret_stb = 1'b1;
    repeat (2) @(negedge clk);
    check_all("R2", 3'd0);
    per_req = 1'b0; dbg_req = 1'b0; exc_req = 1'b0; ret_stb = 1'b0;

    // R5 pending request blocked, then taken once block is cleared
    apply({4'd0,1'b1,1'b0,1'b1,4'd7,1'b0,1'b0,1'b0,1'b0,3'd0}, 20);
    apply({4'd0,1'b0,1'b0,1'b1,4'd7,1'b0,1'b0,1'b0,1'b0,3'd5}, 21);
    chk("R10 normal entry pins", {30'd0, stat_o}, 32'd0);

    // R10 soft-reset status pins: four cycles of 2'b11
    apply({4'd6,1'b1,1'b0,1'b1,4'd9,1'b1,1'b1,1'b0,1'b1,3'd2}, 22);
    chk("R10 pins c1", {30'd0, stat_o}, 32'd3);
    for (int c = 2; c <= 4; c++) begin
      @(negedge clk);
      chk("R10 pins hold", {30'd0, stat_o}, 32'd3);
    end
    @(negedge clk);
    chk("R10 pins release", {30'd0, stat_o}, 32'd0);
    // R9 saved context still that of the earlier entry
    chk("R9 saved pc kept", saved_pc_o, m_spc);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule